// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between a three-phase PWM timing core and the gate drivers. It forces all six switch outputs to a fixed off level whenever a fault is present. A fault can come from an active-low trip pin, from an active-low over-current comparator, or from a software trip strobe. The path from either hardware fault input to the outputs is purely combinational, so the outputs go off even when no clock is running. While the outputs are held off, the core's sync pulse and sync interrupt are blocked. Each new shutdown raises a single-cycle trip interrupt.

Software can learn the cause of the last shutdown from a read-to-clear flag, and it can read the synchronised level of the trip pin. Recovery is deliberate. First the fault must be gone. Then the period register and every phase duty register must each be written. Only after that does the next rising edge of the sync signal release the outputs, and that edge also strobes the new duty values into the core.

Top module: `pwm_fault_guard`

## Requirements
- R1: While `tripPinN` or `senseTripN` is low, `pwmOut` equals the off level (default all zeros) in the same cycle, with no clock edge needed.
- R2: While `shutdownActive` is high or either fault input is low, `pwmOut` equals the off level and `syncOut` and `syncIrqOut` stay low.
- R3: A fault input that goes low and stays low is seen through a two-flop synchroniser. `shutdownActive` and `tripIrq` rise after the third rising clock edge that follows the fall.
- R4: A `swTripWr` pulse sampled while running sets `shutdownActive` and `tripIrq` after that edge.
- R5: `tripIrq` is high for exactly one cycle on each entry into shutdown. A trip request that arrives while already shut down raises no `tripIrq`.
- R6: `swTripFlag` reads 1 when the last shutdown came from a software trip alone, and 0 when it came from hardware. If a software trip and a hardware fault edge arrive together, the shutdown counts as hardware.
- R7: A `swTripRd` pulse without `swTripWr` clears `swTripFlag` after that edge. The flag value is readable during the read cycle itself.
- R8: `pinLevel` equals the level of `tripPinN` two rising edges after the pin changes. It reads 1 after reset.
- R9: Release requires that both fault inputs are high, seen through the synchroniser. After that, `periodWr` and every bit of `dutyWr` must each have pulsed. On the next rising edge of `syncIn`, `dutyLatch` is high for that cycle, and `shutdownActive` falls after that edge.
- R10: Register writes made while a fault is still seen do not count toward release, and a partial set of writes never releases.
- R11: While running with no fault, `pwmOut` follows `pwmIn`, and every rising edge of `syncIn` gives `syncOut` high and a one-cycle `dutyLatch`.
- R12: After reset, `shutdownActive`, `tripIrq`, `swTripFlag` and `dutyLatch` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tripPinN | input | 1 | External trip, active low |
| senseTripN | input | 1 | Over-current comparator trip, active low |
| pwmIn | input | 6 | Switch drives from the timing core |
| syncIn | input | 1 | Sync pulse from the timing core |
| syncIrqIn | input | 1 | Sync interrupt from the timing core |
| swTripWr | input | 1 | Software trip write strobe |
| swTripRd | input | 1 | Read strobe for the trip-cause flag |
| periodWr | input | 1 | Period register write strobe |
| dutyWr | input | 3 | Per-phase duty register write strobes |
| pwmOut | output | 6 | Gated switch drives |
| syncOut | output | 1 | Gated sync pulse |
| syncIrqOut | output | 1 | Gated sync interrupt |
| dutyLatch | output | 1 | Strobe that applies new duty values |
| tripIrq | output | 1 | One-cycle trip interrupt |
| swTripFlag | output | 1 | Trip-cause flag, 1 means software |
| pinLevel | output | 1 | Synchronised trip pin level |
| shutdownActive | output | 1 | Latched shutdown state |

## Verification
The gating results have no register in the path. Output gating, sync blocking and `dutyLatch` are therefore checked one time unit after the input changes, with no clock edge in between. A hardware fault reaches `shutdownActive`, `tripIrq` and `pinLevel` through two synchroniser flops. The shutdown register then adds one more, so the bench checks `pinLevel` after the second edge and the shutdown state after the third. Software trips, flag clears and releases are due one edge after their strobe. Every check samples two time units after a rising edge, where the inputs are also driven.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic holdOff;
    logic latchDuty;
  } ctl_strobe_t;

  // observations from datapath to control
  typedef struct packed {
    logic faultLvl;
    logic faultRise;
    logic syncRise;
  } dp_status_t;

endpackage

// File: rtl/pwm_fault_dp.sv
module pwm_fault_dp
  import pwm_fault_pkg::*;
#(
  parameter int NUM_OUT = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_OUT-1:0] OFF_LEVEL = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tripPinN,
  input  logic               senseTripN,
  input  logic [NUM_OUT-1:0] pwmIn,
  input  logic               syncIn,
  input  logic               syncIrqIn,
  input  ctl_strobe_t        ctlStrb,
  output logic [NUM_OUT-1:0] pwmOut,
  output logic               syncOut,
  output logic               syncIrqOut,
  output logic               dutyLatch,
  output logic               pinLevel,
  output dp_status_t         dpStat
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] rawN;
  logic [NUM_SRC-1:0] syncedN;
  logic               hwRaw;
  logic               blockAll;
  logic               faultPrev;
  logic               syncPrev;
  logic               faultLvl;

  assign rawN = {senseTripN, tripPinN};

  // one synchroniser chain per fault source, reset to the idle (high) level
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawN[s]};
    end
    assign syncedN[s] = chain[SYNC_STAGES-1];
  end

  assign faultLvl = ~&syncedN;
  assign pinLevel = syncedN[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultPrev <= 1'b0;
      syncPrev  <= 1'b0;
    end else begin
      faultPrev <= faultLvl;
      syncPrev  <= syncIn;
    end
  end

  assign dpStat.faultLvl  = faultLvl;
  assign dpStat.faultRise = faultLvl & ~faultPrev;
  assign dpStat.syncRise  = syncIn & ~syncPrev;

  // clockless gating path
  assign hwRaw    = ~tripPinN | ~senseTripN;
  assign blockAll = hwRaw | ctlStrb.holdOff;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
    assign pwmOut[i] = blockAll ? OFF_LEVEL[i] : pwmIn[i];
  end

  assign syncOut    = syncIn & ~blockAll;
  assign syncIrqOut = syncIrqIn & ~blockAll;
  assign dutyLatch  = ctlStrb.latchDuty;

endmodule

// File: rtl/pwm_fault_ctl.sv
module pwm_fault_ctl
  import pwm_fault_pkg::*;
#(
  parameter int NUM_PHASES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dp_status_t            dpStat,
  input  logic                  swTripWr,
  input  logic                  swTripRd,
  input  logic                  periodWr,
  input  logic [NUM_PHASES-1:0] dutyWr,
  output ctl_strobe_t           ctlStrb,
  output logic                  tripIrq,
  output logic                  swTripFlag,
  output logic                  shutdownActive
);

  localparam int NUM_REGS = NUM_PHASES + 1;

  logic                shutdown;
  logic                swFlag;
  logic                irqReg;
  logic [NUM_REGS-1:0] writtenMask;
  logic [NUM_REGS-1:0] regWr;
  logic                newEvent;
  logic                armed;
  logic                release_;

  assign regWr     = {dutyWr, periodWr};
  assign newEvent  = ~shutdown & (dpStat.faultRise | swTripWr);
  assign armed     = &writtenMask;
  assign release_  = shutdown & armed & ~dpStat.faultLvl & dpStat.syncRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutdown    <= 1'b0;
      swFlag      <= 1'b0;
      irqReg      <= 1'b0;
      writtenMask <= '0;
    end else begin
      irqReg <= newEvent;
      if (newEvent) begin
        shutdown    <= 1'b1;
        swFlag      <= ~dpStat.faultRise;
        writtenMask <= '0;
      end else begin
        if (release_) shutdown <= 1'b0;
        if (swTripRd) swFlag   <= 1'b0;
        if (shutdown && dpStat.faultLvl) writtenMask <= '0;
        else if (shutdown)               writtenMask <= writtenMask | regWr;
      end
    end
  end

  assign ctlStrb.holdOff   = shutdown;
  assign ctlStrb.latchDuty = dpStat.syncRise & (~shutdown | release_);
  assign tripIrq           = irqReg;
  assign swTripFlag        = swFlag;
  assign shutdownActive    = shutdown;

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwm_fault_pkg::*;
#(
  parameter int NUM_PHASES = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [2*NUM_PHASES-1:0] OFF_LEVEL = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tripPinN,
  input  logic                    senseTripN,
  input  logic [2*NUM_PHASES-1:0] pwmIn,
  input  logic                    syncIn,
  input  logic                    syncIrqIn,
  input  logic                    swTripWr,
  input  logic                    swTripRd,
  input  logic                    periodWr,
  input  logic [NUM_PHASES-1:0]   dutyWr,
  output logic [2*NUM_PHASES-1:0] pwmOut,
  output logic                    syncOut,
  output logic                    syncIrqOut,
  output logic                    dutyLatch,
  output logic                    tripIrq,
  output logic                    swTripFlag,
  output logic                    pinLevel,
  output logic                    shutdownActive
);

  localparam int NUM_OUT = 2 * NUM_PHASES;

  ctl_strobe_t ctlStrb;
  dp_status_t  dpStat;

  pwm_fault_dp #(
    .NUM_OUT(NUM_OUT),
    .SYNC_STAGES(SYNC_STAGES),
    .OFF_LEVEL(OFF_LEVEL)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .tripPinN(tripPinN), .senseTripN(senseTripN),
    .pwmIn(pwmIn), .syncIn(syncIn), .syncIrqIn(syncIrqIn),
    .ctlStrb(ctlStrb),
    .pwmOut(pwmOut), .syncOut(syncOut), .syncIrqOut(syncIrqOut),
    .dutyLatch(dutyLatch), .pinLevel(pinLevel), .dpStat(dpStat)
  );

  pwm_fault_ctl #(
    .NUM_PHASES(NUM_PHASES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .dpStat(dpStat),
    .swTripWr(swTripWr), .swTripRd(swTripRd),
    .periodWr(periodWr), .dutyWr(dutyWr),
    .ctlStrb(ctlStrb), .tripIrq(tripIrq),
    .swTripFlag(swTripFlag), .shutdownActive(shutdownActive)
  );

endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
  parameter int NUM_PHASES = 3,
  parameter logic [2*NUM_PHASES-1:0] OFF_LEVEL = '0
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    tripPinN,
  input logic                    senseTripN,
  input logic                    swTripWr,
  input logic                    swTripRd,
  input logic [2*NUM_PHASES-1:0] pwmOut,
  input logic                    syncOut,
  input logic                    syncIrqOut,
  input logic                    dutyLatch,
  input logic                    tripIrq,
  input logic                    swTripFlag,
  input logic                    shutdownActive
);

  assert_fault_forces_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!tripPinN || !senseTripN) |-> pwmOut == OFF_LEVEL);

  assert_shutdown_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    shutdownActive |-> (pwmOut == OFF_LEVEL) && !syncOut && !syncIrqOut);

  assert_sw_trip_enters_R4: assert property (@(posedge clk) disable iff (!rstN)
    (swTripWr && !shutdownActive) |=> shutdownActive && tripIrq);

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    tripIrq |=> !tripIrq);

  assert_irq_on_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    tripIrq |-> shutdownActive && !$past(shutdownActive));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (swTripRd && !swTripWr) |=> !swTripFlag);

  assert_release_on_latch_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dutyLatch && shutdownActive) |=> !shutdownActive);

endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(
  .NUM_PHASES(NUM_PHASES),
  .OFF_LEVEL(OFF_LEVEL)
) u_chk (
  .clk(clk), .rstN(rstN), .tripPinN(tripPinN), .senseTripN(senseTripN),
  .swTripWr(swTripWr), .swTripRd(swTripRd), .pwmOut(pwmOut),
  .syncOut(syncOut), .syncIrqOut(syncIrqOut), .dutyLatch(dutyLatch),
  .tripIrq(tripIrq), .swTripFlag(swTripFlag), .shutdownActive(shutdownActive)
);

// File: tb/test_pwm_fault_guard.sv
`timescale 1ns/1ps
module test_pwm_fault_guard;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tripPinN = 1'b1;
  logic       senseTripN = 1'b1;
  logic [5:0] pwmIn = 6'b101101;
  logic       syncIn = 1'b0;
  logic       syncIrqIn = 1'b0;
  logic       swTripWr = 1'b0;
  logic       swTripRd = 1'b0;
  logic       periodWr = 1'b0;
  logic [2:0] dutyWr = 3'b000;
  logic [5:0] pwmOut;
  logic       syncOut, syncIrqOut, dutyLatch, tripIrq, swTripFlag, pinLevel, shutdownActive;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwm_fault_guard i_pwm_fault_guard (
    .clk(clk), .rstN(rstN), .tripPinN(tripPinN), .senseTripN(senseTripN),
    .pwmIn(pwmIn), .syncIn(syncIn), .syncIrqIn(syncIrqIn),
    .swTripWr(swTripWr), .swTripRd(swTripRd), .periodWr(periodWr), .dutyWr(dutyWr),
    .pwmOut(pwmOut), .syncOut(syncOut), .syncIrqOut(syncIrqOut), .dutyLatch(dutyLatch),
    .tripIrq(tripIrq), .swTripFlag(swTripFlag), .pinLevel(pinLevel),
    .shutdownActive(shutdownActive)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  // pulse selected register writes: bit0 period, bits 3:1 duty
  task automatic writeRegs(logic [3:0] m);
    periodWr = m[0];
    dutyWr   = m[3:1];
    tick();
    periodWr = 1'b0;
    dutyWr   = 3'b000;
  endtask

  // rising sync edge; returns dutyLatch seen in the rise cycle
  task automatic syncPulse(output logic latched, output logic syncSeen);
    syncIn = 1'b1;
    syncIrqIn = 1'b1;
    #1;
    latched = dutyLatch;
    syncSeen = syncOut | syncIrqOut;
    tick();
    syncIn = 1'b0;
    syncIrqIn = 1'b0;
    tick();
  endtask

  task automatic testReset();
    chk("R12", "shutdownActive", shutdownActive, 0);
    chk("R12", "tripIrq", tripIrq, 0);
    chk("R12", "swTripFlag", swTripFlag, 0);
    chk("R12", "dutyLatch", dutyLatch, 0);
    chk("R8", "pinLevel after reset", pinLevel, 1);
  endtask

  task automatic testRun();
    logic l, s;
    pwmIn = 6'b010011;
    #1 chk("R11", "pwmOut follows", pwmOut, 6'b010011);
    pwmIn = 6'b101101;
    #1 chk("R11", "pwmOut follows 2", pwmOut, 6'b101101);
    syncPulse(l, s);
    chk("R11", "dutyLatch on sync", l, 1);
    chk("R11", "syncOut passes", s, 1);
  endtask

  task automatic testPinTrip();
    logic l, s;
    tripPinN = 1'b0;
    #1 chk("R1", "pwmOut off no clock", pwmOut, 0);
    tick(2);
    chk("R8", "pinLevel low after 2 edges", pinLevel, 0);
    chk("R3", "no shutdown after 2 edges", shutdownActive, 0);
    tick();
    chk("R3", "shutdown after 3 edges", shutdownActive, 1);
    chk("R5", "tripIrq on entry", tripIrq, 1);
    chk("R6", "hw cause flag", swTripFlag, 0);
    tick();
    chk("R5", "tripIrq one cycle", tripIrq, 0);
    syncIn = 1'b1; syncIrqIn = 1'b1;
    #1 chk("R2", "sync blocked", {syncOut, syncIrqOut}, 0);
    tick(); syncIn = 1'b0; syncIrqIn = 1'b0; tick();
    swTripWr = 1'b1; tick(); swTripWr = 1'b0;
    chk("R5", "no irq while shut down", tripIrq, 0);
    writeRegs(4'b1111);
    tripPinN = 1'b1;
    tick(2);
    chk("R8", "pinLevel high again", pinLevel, 1);
    tick();
    syncPulse(l, s);
    chk("R10", "no latch with writes during fault", l, 0);
    chk("R10", "still shut down", shutdownActive, 1);
    writeRegs(4'b0111);
    syncPulse(l, s);
    chk("R10", "partial writes no latch", l, 0);
    chk("R10", "partial writes hold", shutdownActive, 1);
    chk("R2", "outputs held off", pwmOut, 0);
    writeRegs(4'b1000);
    syncIn = 1'b1;
    #1 chk("R9", "dutyLatch on release edge", dutyLatch, 1);
    chk("R2", "sync still blocked in release cycle", syncOut, 0);
    tick();
    chk("R9", "shutdown released", shutdownActive, 0);
    chk("R9", "pwmOut restored", pwmOut, pwmIn);
    syncIn = 1'b0;
    tick();
  endtask

  task automatic testSenseTrip();
    logic l, s;
    senseTripN = 1'b0;
    #1 chk("R1", "sense trip off", pwmOut, 0);
    tick(3);
    chk("R3", "sense shutdown", shutdownActive, 1);
    chk("R5", "sense irq", tripIrq, 1);
    senseTripN = 1'b1;
    tick(3);
    writeRegs(4'b1111);
    syncPulse(l, s);
    chk("R9", "sense release latch", l, 1);
    chk("R9", "sense released", shutdownActive, 0);
  endtask

  task automatic testSwTrip();
    logic l, s;
    swTripWr = 1'b1;
    tick();
    swTripWr = 1'b0;
    chk("R4", "sw shutdown", shutdownActive, 1);
    chk("R4", "sw irq", tripIrq, 1);
    chk("R2", "sw outputs off", pwmOut, 0);
    chk("R6", "sw cause flag", swTripFlag, 1);
    swTripRd = 1'b1;
    #1 chk("R7", "flag visible in read cycle", swTripFlag, 1);
    tick();
    swTripRd = 1'b0;
    chk("R7", "flag cleared by read", swTripFlag, 0);
    writeRegs(4'b1111);
    syncPulse(l, s);
    chk("R9", "sw release", shutdownActive, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(2);
    rstN = 1'b1;
    tick(2);
    testReset();
    testRun();
    testPinTrip();
    testSenseTrip();
    testSwTrip();
    testRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule